// File: doc/BRIEF.md
# Security-Gated Interrupt Flag Register

This block holds the pending flags for sixteen external interrupt lines and one security-check flag. All of them sit in a single 32-bit word that software reads and clears by writing ones. A one-cycle pulse on a line's sense input sets that line's flag. The sense logic that detects edges or levels sits outside this block. The block drives a single interrupt request. Each line flag contributes to it through a per-line enable input, and the check flag contributes through its own enable.

Every register access carries a secure or non-secure attribute. A secure master sees and clears every implemented bit. A non-secure master sees and clears only the lines whose bit is set in the non-secure attribute vector. The security-check flag sits at bit 31. It rises when the attribute vector or the check-enable vector is written and, after that write, some line has its check enable set while it is still marked secure. This lets firmware detect a configuration that leaves an enabled line out of reach of the non-secure world.

Top module: `xint_flag_reg`

## Requirements
- R1: After reset every flag is 0, `irqOut` is 0 and `regRdata` is 0.
- R2: A 1 on `sense[x]` at a clock edge sets flag x, and the flag can be read from the next cycle on.
- R3: A secure write at offset 0x14 clears every flag whose data bit is 1. Bits 15:0 are the line flags and bit 31 is the check flag. Data bits that are 0 leave their flags unchanged.
- R4: When a sense pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: A non-secure read at offset 0x14 returns flag x only where `nsAttr[x]` is 1. It returns 0 for every other line and 0 at bit 31.
- R6: A non-secure write at offset 0x14 clears only the flags of lines with `nsAttr[x]` at 1. It has no effect on secure lines or on bit 31.
- R7: When `cfgWr` is 1 and some line has `chkEn` at 1 and `nsAttr` at 0, the check flag becomes 1 at that edge. This takes priority over a clear in the same cycle. When every check-enabled line is non-secure, `cfgWr` leaves the flag unchanged.
- R8: `irqOut` is 1 exactly when some flag x is set with `lineEn[x]` at 1, or when the check flag is set with `chkIrqEn` at 1.
- R9: Bits 30:16 always read as 0. Writes to any offset other than 0x14 change no flag, and reads at any other offset return 0.
- R10: Read data is registered. `regRdata` holds the word sampled at the edge where `regRe` was high, showing the flags before that edge's update, and it is 0 in the cycle after any edge without a read hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sense | input | 16 | Per-line set pulses from the sense logic |
| lineEn | input | 16 | Per-line interrupt enable |
| chkIrqEn | input | 1 | Interrupt enable for the check flag |
| nsAttr | input | 16 | Per-line non-secure attribute (1 = non-secure) |
| chkEn | input | 16 | Per-line security-check enable |
| cfgWr | input | 1 | Pulse: the attribute or check-enable register was written, and the new values are on `nsAttr`/`chkEn` |
| regAddr | input | 8 | Byte offset of the access |
| regWe | input | 1 | Write enable |
| regRe | input | 1 | Read enable |
| regNonSec | input | 1 | Access attribute (1 = non-secure) |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Registered read data |
| irqOut | output | 1 | Combined interrupt request |

## Verification
Flag updates from sense pulses, clearing writes and `cfgWr` take effect at the sampling edge and show up on `regRdata` only one edge after a later read. A directed readback therefore observes them two edges after the stimulus. `irqOut` follows the flag registers combinationally, so it changes in the cycle right after the edge that changed a flag, or at once when an enable changes. The bench drives inputs one nanosecond after the rising edge. Its behavioural model advances at the rising edge, and the bench compares `irqOut` and `regRdata` with the model at every falling edge, so each result is checked in the cycle it is due.

// File: rtl/xint_flag_pkg.sv
package xint_flag_pkg;
  parameter int unsigned LINES  = 16;
  parameter int unsigned DATA_W = 32;
  parameter int unsigned CHK_BIT = DATA_W - 1;

  typedef struct packed {
    logic [LINES-1:0] clrMask;  // line flags to clear this cycle
    logic             clrChk;   // clear the check flag
    logic             setChk;   // raise the check flag
    logic             rdLoad;   // capture a read word
    logic [LINES-1:0] rdMask;   // lines visible to the reader
    logic             rdChk;    // check flag visible to the reader
  } strobe_t;
endpackage

// File: rtl/xint_flag_ctrl.sv
module xint_flag_ctrl
  import xint_flag_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h14
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic              regRe,
  input  logic              regNonSec,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [LINES-1:0]  nsAttr,
  input  logic [LINES-1:0]  chkEn,
  input  logic              cfgWr,
  output strobe_t           st
);
  logic             hit;
  logic             wrHit;
  logic [LINES-1:0] accessMask;
  logic [LINES-1:0] exposedLines;
  logic             unusedWdata;

  assign hit          = (regAddr == REG_OFFSET);
  assign wrHit        = regWe && hit;
  assign accessMask   = regNonSec ? nsAttr : {LINES{1'b1}};
  assign exposedLines = chkEn & ~nsAttr;
  assign unusedWdata  = ^regWdata[CHK_BIT-1:LINES];

  always_comb begin
    st         = '0;
    st.clrMask = wrHit ? (regWdata[LINES-1:0] & accessMask) : '0;
    st.clrChk  = wrHit && !regNonSec && regWdata[CHK_BIT];
    st.setChk  = cfgWr && (|exposedLines);
    st.rdLoad  = regRe && hit;
    st.rdMask  = accessMask;
    st.rdChk   = !regNonSec;
  end
endmodule

// File: rtl/xint_flag_dp.sv
module xint_flag_dp
  import xint_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  sense,
  input  logic [LINES-1:0]  lineEn,
  input  logic              chkIrqEn,
  input  strobe_t           st,
  output logic [LINES-1:0]  flagQ,
  output logic              chkQ,
  output logic [DATA_W-1:0] rdataQ,
  output logic              irqOut
);
  logic [LINES-1:0]  lineReq;
  logic [DATA_W-1:0] rdWord;

  // set has priority over clear: OR the pulses after masking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ  <= '0;
      chkQ   <= 1'b0;
      rdataQ <= '0;
    end else begin
      flagQ  <= (flagQ & ~st.clrMask) | sense;
      chkQ   <= (chkQ & ~st.clrChk) | st.setChk;
      rdataQ <= st.rdLoad ? rdWord : '0;
    end
  end

  always_comb begin
    rdWord                = '0;
    rdWord[LINES-1:0]     = flagQ & st.rdMask;
    rdWord[CHK_BIT]       = chkQ & st.rdChk;
  end

  for (genvar i = 0; i < LINES; i++) begin : g_req
    assign lineReq[i] = flagQ[i] & lineEn[i];
  end

  assign irqOut = (|lineReq) | (chkQ & chkIrqEn);
endmodule

// File: rtl/xint_flag_reg.sv
module xint_flag_reg
  import xint_flag_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       sense,
  input  logic [15:0]       lineEn,
  input  logic              chkIrqEn,
  input  logic [15:0]       nsAttr,
  input  logic [15:0]       chkEn,
  input  logic              cfgWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic              regRe,
  input  logic              regNonSec,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              irqOut
);
  strobe_t          st;
  logic [LINES-1:0] flagQ;
  logic             chkQ;

  xint_flag_ctrl #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_ctrl (
    .regAddr(regAddr), .regWe(regWe), .regRe(regRe), .regNonSec(regNonSec),
    .regWdata(regWdata), .nsAttr(nsAttr), .chkEn(chkEn), .cfgWr(cfgWr),
    .st(st)
  );

  xint_flag_dp u_dp (
    .clk(clk), .rstN(rstN), .sense(sense), .lineEn(lineEn),
    .chkIrqEn(chkIrqEn), .st(st), .flagQ(flagQ), .chkQ(chkQ),
    .rdataQ(regRdata), .irqOut(irqOut)
  );
endmodule

// File: rtl/xint_flag_chk.sv
module xint_flag_chk
  import xint_flag_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h14
) (
  input logic              clk,
  input logic              rstN,
  input logic [LINES-1:0]  sense,
  input logic [LINES-1:0]  lineEn,
  input logic              chkIrqEn,
  input logic [LINES-1:0]  nsAttr,
  input logic [LINES-1:0]  chkEn,
  input logic              cfgWr,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWe,
  input logic              regRe,
  input logic              regNonSec,
  input logic [DATA_W-1:0] regWdata,
  input logic [DATA_W-1:0] regRdata,
  input logic              irqOut,
  input logic [LINES-1:0]  flagQ,
  input logic              chkQ
);
  logic hit;
  assign hit = (regAddr == REG_OFFSET);

  // R2 / R4: a pulsed line is set after the edge, whatever else happened
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (sense != '0) |=> ((flagQ & $past(sense)) == $past(sense)));

  // R3: a flag only falls when a hit write carried a 1 on its bit
  a_r3_only_w1c: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(flagQ) & ~flagQ) &
               ~($past(regWdata[LINES-1:0]) & {LINES{$past(regWe && hit)}})) == '0));

  // R6: non-secure writes never clear secure lines or the check flag
  a_r6_ns_write: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && hit && regNonSec && !cfgWr) |=>
      (((($past(flagQ) & ~flagQ) & ~$past(nsAttr)) == '0) && !($past(chkQ) && !chkQ)));

  // R5: non-secure reads hide secure lines and bit 31
  a_r5_ns_read: assert property (@(posedge clk) disable iff (!rstN)
    (regRe && hit && regNonSec) |=>
      ((regRdata[LINES-1:0] & ~$past(nsAttr)) == '0) && !regRdata[CHK_BIT]);

  // R7: an exposed enabled line raises the check flag
  a_r7_chk_set: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && ((chkEn & ~nsAttr) != '0)) |=> chkQ);

  // R8: no pending enabled source, no request; an enabled line flag forces it
  a_r8_irq_idle: assert property (@(posedge clk) disable iff (!rstN)
    ((flagQ == '0) && !chkQ) |-> !irqOut);
  a_r8_irq_line: assert property (@(posedge clk) disable iff (!rstN)
    (((flagQ & lineEn) != '0) || (chkQ && chkIrqEn)) |-> irqOut);

  // R9: reserved bits read as zero
  a_r9_reserved: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[CHK_BIT-1:LINES] == '0);

  // R10: no read hit, zero data next cycle
  a_r10_idle_rd: assert property (@(posedge clk) disable iff (!rstN)
    !(regRe && hit) |=> (regRdata == '0));
endmodule

bind xint_flag_reg xint_flag_chk #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_chk (.*);

// File: tb/xint_flag_reg_test.sv
`timescale 1ns/1ps
module xint_flag_reg_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] sense = '0, lineEn = '0, nsAttr = '0, chkEn = '0;
  logic        chkIrqEn = 1'b0, cfgWr = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWe = 1'b0, regRe = 1'b0, regNonSec = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irqOut;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string curReq = "R1";

  // behavioural reference state
  logic [15:0] mFlags = '0;
  logic        mChk = 1'b0;
  logic [31:0] mRd = '0;

  always #2.5 clk = ~clk;

  xint_flag_reg uut (
    .clk(clk), .rstN(rstN), .sense(sense), .lineEn(lineEn), .chkIrqEn(chkIrqEn),
    .nsAttr(nsAttr), .chkEn(chkEn), .cfgWr(cfgWr), .regAddr(regAddr),
    .regWe(regWe), .regRe(regRe), .regNonSec(regNonSec), .regWdata(regWdata),
    .regRdata(regRdata), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic [31:0] nextRd;
    if (!rstN) begin
      mFlags = '0; mChk = 1'b0; mRd = '0;
    end else begin
      nextRd = '0;
      if (regRe && regAddr == 8'h14)
        nextRd = regNonSec ? {16'h0, mFlags & nsAttr} : {mChk, 15'h0, mFlags};
      if (regWe && regAddr == 8'h14) begin
        for (int i = 0; i < 16; i++)
          if (regWdata[i] && (!regNonSec || nsAttr[i])) mFlags[i] = 1'b0;
        if (!regNonSec && regWdata[31]) mChk = 1'b0;
      end
      mFlags = mFlags | sense;
      if (cfgWr && ((chkEn & ~nsAttr) != 16'h0)) mChk = 1'b1;
      mRd = nextRd;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      check({curReq, " irqOut R8"}, {31'h0, irqOut},
            {31'h0, (|(mFlags & lineEn)) | (mChk & chkIrqEn)});
      check({curReq, " regRdata R10"}, regRdata, mRd);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic ns, input logic [7:0] a, input logic [31:0] d);
    regWe = 1'b1; regNonSec = ns; regAddr = a; regWdata = d;
    tick();
    regWe = 1'b0; regWdata = '0; regNonSec = 1'b0;
  endtask

  task automatic rd(input logic ns, input logic [7:0] a, output logic [31:0] v);
    regRe = 1'b1; regNonSec = ns; regAddr = a;
    tick();
    v = regRdata;
    regRe = 1'b0; regNonSec = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] s);
    sense = s; tick(); sense = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog R1 actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1;
    check("R1 irq at reset", {31'h0, irqOut}, 32'h0);
    check("R1 rdata at reset", regRdata, 32'h0);
    rstN = 1'b1;
    tick();
    rd(1'b0, 8'h14, v); check("R1 flags after reset", v, 32'h0);

    curReq = "R2";
    pulse(16'h0005);
    rd(1'b0, 8'h14, v); check("R2 sense sets", v, 32'h0000_0005);
    lineEn = 16'h0004; #1;
    check("R8 enabled line drives irq", {31'h0, irqOut}, 32'h1);
    lineEn = 16'h0008; #1;
    check("R8 disabled lines quiet", {31'h0, irqOut}, 32'h0);

    curReq = "R3";
    wr(1'b0, 8'h14, 32'h0000_0001);
    rd(1'b0, 8'h14, v); check("R3 write one clears", v, 32'h0000_0004);
    wr(1'b0, 8'h14, 32'h0000_0000);
    rd(1'b0, 8'h14, v); check("R3 write zero no effect", v, 32'h0000_0004);

    curReq = "R4";
    sense = 16'h0004;
    wr(1'b0, 8'h14, 32'h0000_0004);
    sense = '0;
    rd(1'b0, 8'h14, v); check("R4 set beats clear", v, 32'h0000_0004);

    curReq = "R5";
    nsAttr = 16'h00F0;
    pulse(16'h0030);
    rd(1'b1, 8'h14, v); check("R5 ns read filtered", v, 32'h0000_0030);
    curReq = "R6";
    wr(1'b1, 8'h14, 32'hFFFF_FFFF);
    rd(1'b0, 8'h14, v); check("R6 ns write only ns lines", v, 32'h0000_0004);

    curReq = "R7";
    chkEn = 16'h0100; cfgWr = 1'b1; tick(); cfgWr = 1'b0;
    rd(1'b0, 8'h14, v); check("R7 check flag set", v, 32'h8000_0004);
    rd(1'b1, 8'h14, v); check("R5 ns read hides bit 31", v, 32'h0000_0000);
    lineEn = '0; chkIrqEn = 1'b1; #1;
    check("R8 check flag irq", {31'h0, irqOut}, 32'h1);
    wr(1'b1, 8'h14, 32'h8000_0000);
    rd(1'b0, 8'h14, v); check("R6 ns write bit 31 ignored", v, 32'h8000_0004);

    curReq = "R9";
    wr(1'b0, 8'h18, 32'hFFFF_FFFF);
    rd(1'b0, 8'h14, v); check("R9 other offset write ignored", v, 32'h8000_0004);
    rd(1'b0, 8'h18, v); check("R9 other offset reads zero", v, 32'h0);
    wr(1'b0, 8'h14, 32'h7FFF_0000);
    rd(1'b0, 8'h14, v); check("R9 reserved bits zero", v, 32'h8000_0004);

    curReq = "R3";
    wr(1'b0, 8'h14, 32'h8000_0000);
    rd(1'b0, 8'h14, v); check("R3 check flag cleared", v, 32'h0000_0004);

    curReq = "R7";
    chkEn = 16'h00F0; cfgWr = 1'b1; tick(); cfgWr = 1'b0;
    rd(1'b0, 8'h14, v); check("R7 no exposed line no flag", v, 32'h0000_0004);

    curReq = "R10";
    tick();
    check("R10 idle read data zero", regRdata, 32'h0);

    curReq = "random R4 R6 R7";
    for (int n = 0; n < 400; n++) begin
      sense     = ($urandom_range(0, 3) == 0) ? 16'($urandom) : '0;
      lineEn    = 16'($urandom);
      chkIrqEn  = 1'($urandom);
      nsAttr    = 16'($urandom);
      chkEn     = ($urandom_range(0, 1) == 0) ? '0 : 16'($urandom);
      cfgWr     = ($urandom_range(0, 7) == 0);
      regAddr   = ($urandom_range(0, 5) == 0) ? 8'h10 : 8'h14;
      regWe     = 1'($urandom);
      regRe     = 1'($urandom);
      regNonSec = 1'($urandom);
      regWdata  = $urandom;
      tick();
    end
    sense = '0; cfgWr = 1'b0; regWe = 1'b0; regRe = 1'b0;
    tick(); tick();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule